// File: doc/BRIEF.md
# Set-Clear Clock Enable and Reset Control Bank

This block holds two control vectors for a group of peripherals: a clock-enable vector whose bits feed glitch-free clock gate cells, and a reset vector whose bits hold peripherals in reset. Software never rewrites a whole vector. Each vector has three word addresses. The first sets the bits written as 1. The second clears the bits written as 1. The third returns the current vector value. Because bits written as 0 are left alone, drivers for different peripherals can share the bank without a read-modify-write sequence.

Access is through a simple synchronous register bus with a single port. Writes take effect at the clock edge that samples them, and the registered outputs move at that same edge. Read data is registered, so it appears one clock after the read is sampled. Gating a clock only switches it on or off. The parent frequency seen by each gate cell stays fixed.

Top module: `sc_gate_bank`

## Requirements
- R1: While reset is high and at the first edge after it, clk_en_o is all 0, periph_rst_o is all 1 and bus_rdata is 0.
- R2: A write to byte address 0x00 sets every clk_en_o bit that is 1 in bus_wdata and leaves the others unchanged, visible right after the sampling edge.
- R3: A write to address 0x04 clears every clk_en_o bit that is 1 in bus_wdata and leaves the others unchanged.
- R4: A read of address 0x08 returns clk_en_o as it was at the sampling edge, on bus_rdata one clock later.
- R5: The reset vector uses RST_BASE (0x10) for set, RST_BASE+0x04 for clear and RST_BASE+0x08 for status, with the same behaviour as R2 to R4. Clearing a bit drives that periph_rst_o bit low and releases the peripheral.
- R6: Reads of the four set and clear addresses, and of any address outside the six defined ones, return 0.
- R7: Writes to the two status addresses and to any undefined address change neither vector.
- R8: Writes to the enable addresses never change periph_rst_o, and writes to the reset addresses never change clk_en_o.
- R9: In any cycle after a clock edge where bus_rd was low, bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data / bit mask |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| clk_en_o | output | DATA_W | Per-peripheral clock enables to the gate cells |
| periph_rst_o | output | DATA_W | Per-peripheral resets, high = held |

## Verification
The bench builds the bank with its defaults: a 32-bit data width, an 8-bit address and the reset triplet at 0x10. With these values, random 32-bit masks reach every bit position of both vectors. The random addresses cover the whole 256-entry space, so misaligned and unmapped addresses occur as well as the six defined ones. Directed cases add all-ones and all-zeros masks, status writes, and the release of reset bits after power-on.

// File: rtl/sc_gate_pkg.sv
package sc_gate_pkg;

    localparam int DEF_DATA_W = 32;
    localparam int DEF_ADDR_W = 8;
    localparam int NUM_VEC    = 2;

    // byte offsets inside one triplet
    localparam int OFS_SET  = 0;
    localparam int OFS_CLR  = 4;
    localparam int OFS_STAT = 8;

    typedef enum logic [1:0] {
        VEC_ENABLE = 2'd0,
        VEC_RESET  = 2'd1
    } vec_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2,
        ACC_STAT = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e kind;
        vec_e vec;
    } access_t;

    // next value of one vector from its set and clear masks (clear wins)
    function automatic logic [DEF_DATA_W-1:0] vec_next(
        input logic [DEF_DATA_W-1:0] cur,
        input logic [DEF_DATA_W-1:0] set_m,
        input logic [DEF_DATA_W-1:0] clr_m
    );
        return (cur | set_m) & ~clr_m;
    endfunction

endpackage

// File: rtl/sc_addr_decode.sv
module sc_addr_decode
    import sc_gate_pkg::*;
#(
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int RST_BASE = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output access_t           acc
);
    localparam int EN_BASE = 0;

    always_comb begin
        acc = '{kind: ACC_NONE, vec: VEC_ENABLE};
        for (int v = 0; v < NUM_VEC; v++) begin
            int base;
            base = (v == 0) ? EN_BASE : RST_BASE;
            if (addr == ADDR_W'(base + OFS_SET)) begin
                acc.kind = ACC_SET;
                acc.vec  = vec_e'(v);
            end else if (addr == ADDR_W'(base + OFS_CLR)) begin
                acc.kind = ACC_CLR;
                acc.vec  = vec_e'(v);
            end else if (addr == ADDR_W'(base + OFS_STAT)) begin
                acc.kind = ACC_STAT;
                acc.vec  = vec_e'(v);
            end
        end
    end

endmodule

// File: rtl/sc_bit_vector.sv
module sc_bit_vector #(
    parameter int   W         = 32,
    parameter logic RESET_BIT = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q[b] <= RESET_BIT;
            end else if (clr_mask[b]) begin
                q[b] <= 1'b0;
            end else if (set_mask[b]) begin
                q[b] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sc_read_mux.sv
module sc_read_mux
    import sc_gate_pkg::*;
#(
    parameter int W = DEF_DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd,
    input  access_t      acc,
    input  logic [W-1:0] en_vec,
    input  logic [W-1:0] rst_vec,
    output logic [W-1:0] rdata
);
    logic [W-1:0] sel_d;

    always_comb begin
        sel_d = '0;
        if (rd && acc.kind == ACC_STAT) begin
            sel_d = (acc.vec == VEC_RESET) ? rst_vec : en_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            rdata <= sel_d;
        end
    end

endmodule

// File: rtl/sc_gate_bank.sv
module sc_gate_bank
    import sc_gate_pkg::*;
#(
    parameter int DATA_W   = DEF_DATA_W,
    parameter int ADDR_W   = DEF_ADDR_W,
    parameter int RST_BASE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] clk_en_o,
    output logic [DATA_W-1:0] periph_rst_o
);
    access_t     acc;
    logic [DATA_W-1:0] vec_q [NUM_VEC];

    sc_addr_decode #(
        .ADDR_W  (ADDR_W),
        .RST_BASE(RST_BASE)
    ) dec_i (
        .addr(bus_addr),
        .acc (acc)
    );

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        logic hit;
        logic [DATA_W-1:0] set_m, clr_m;

        assign hit   = bus_wr && (acc.vec == vec_e'(v));
        assign set_m = (hit && acc.kind == ACC_SET) ? bus_wdata : '0;
        assign clr_m = (hit && acc.kind == ACC_CLR) ? bus_wdata : '0;

        sc_bit_vector #(
            .W        (DATA_W),
            .RESET_BIT((v == 0) ? 1'b0 : 1'b1)
        ) vec_i (
            .clk     (clk),
            .rst     (rst),
            .set_mask(set_m),
            .clr_mask(clr_m),
            .q       (vec_q[v])
        );
    end

    assign clk_en_o     = vec_q[0];
    assign periph_rst_o = vec_q[1];

    sc_read_mux #(
        .W(DATA_W)
    ) rmux_i (
        .clk    (clk),
        .rst    (rst),
        .rd     (bus_rd),
        .acc    (acc),
        .en_vec (vec_q[0]),
        .rst_vec(vec_q[1]),
        .rdata  (bus_rdata)
    );

endmodule

// File: rtl/sc_gate_bank_chk.sv
module sc_gate_bank_chk #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int RST_BASE = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] clk_en_o,
    input logic [DATA_W-1:0] periph_rst_o
);
    localparam logic [ADDR_W-1:0] A_ESET  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_ECLR  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_ESTAT = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_RCLR  = ADDR_W'(RST_BASE + 4);
    localparam logic [ADDR_W-1:0] A_RSTAT = ADDR_W'(RST_BASE + 8);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (clk_en_o == '0 && periph_rst_o == '1 && bus_rdata == '0));

    p_set_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_ESET) |=> ((clk_en_o & $past(bus_wdata)) == $past(bus_wdata)));

    p_clr_bits_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_ECLR) |=> ((clk_en_o & $past(bus_wdata)) == '0));

    p_en_status_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_ESTAT) |=> (bus_rdata == $past(clk_en_o)));

    p_rst_release_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_RCLR) |=> ((periph_rst_o & $past(bus_wdata)) == '0));

    p_rst_status_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_RSTAT) |=> (bus_rdata == $past(periph_rst_o)));

    p_no_write_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr || bus_addr == A_ESTAT || bus_addr == A_RSTAT)
            |=> ($stable(clk_en_o) && $stable(periph_rst_o)));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));

endmodule

bind sc_gate_bank sc_gate_bank_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .RST_BASE(RST_BASE)
) chk_i (.*);

// File: tb/sc_gate_bank_tb.sv
module sc_gate_bank_tb_top;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int RB = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_rdata, clk_en_o, periph_rst_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] m_en, m_rst;

    always #10 clk = ~clk;

    sc_gate_bank #(.DATA_W(DW), .ADDR_W(AW), .RST_BASE(RB)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .clk_en_o(clk_en_o), .periph_rst_o(periph_rst_o)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected read data from requirements R4, R5, R6
    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a,
                                               input logic [DW-1:0] e, input logic [DW-1:0] r);
        if (a == AW'(8))       return e;
        if (a == AW'(RB + 8))  return r;
        return '0;
    endfunction

    function automatic string tag_of(input logic [AW-1:0] a);
        if (a == AW'(0))      return "R2";
        if (a == AW'(4))      return "R3";
        if (a == AW'(8))      return "R4";
        if (a == AW'(RB))     return "R5";
        if (a == AW'(RB + 4)) return "R5";
        if (a == AW'(RB + 8)) return "R5";
        return "R7";
    endfunction

    // one bus cycle; write effects modelled per R2, R3, R5, R7, R8
    task automatic op(input logic wr, input logic rd, input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] er;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        er = rd ? exp_read(a, m_en, m_rst) : '0;
        if (wr) begin
            if (a == AW'(0))      m_en  = m_en | d;
            if (a == AW'(4))      m_en  = m_en & ~d;
            if (a == AW'(RB))     m_rst = m_rst | d;
            if (a == AW'(RB + 4)) m_rst = m_rst & ~d;
        end
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        check({tag_of(a), "/R8 enable"}, clk_en_o, m_en);
        check({tag_of(a), "/R8 reset"}, periph_rst_o, m_rst);
        if (rd) check((a == AW'(0) || a == AW'(4) || a == AW'(RB) || a == AW'(RB + 4)) ? "R6 read"
                      : (exp_read(a, '1, '1) == '0 ? "R6 unmapped" : tag_of(a)), bus_rdata, er);
        else    check("R9 idle rdata", bus_rdata, '0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] addrs [7];
        void'($urandom(32'd1234));
        addrs = '{AW'(0), AW'(4), AW'(8), AW'(RB), AW'(RB + 4), AW'(RB + 8), AW'(12)};
        m_en = '0; m_rst = '1;
        repeat (3) @(negedge clk);
        check("R1 enable", clk_en_o, '0);
        check("R1 reset", periph_rst_o, '1);
        check("R1 rdata", bus_rdata, '0);
        rst = 0;
        // directed corners
        op(1, 0, AW'(0), 32'hFFFF_FFFF);          // R2 all ones
        op(0, 1, AW'(8), '0);                     // R4
        op(1, 0, AW'(4), 32'h0000_0000);          // R3 zero mask
        op(1, 0, AW'(4), 32'hA5A5_0001);          // R3
        op(1, 0, AW'(8), 32'h0);                  // R7 status write
        op(1, 0, AW'(RB + 8), 32'h0);             // R7 status write
        op(1, 0, AW'(RB + 4), 32'h8000_0001);     // R5 release
        op(0, 1, AW'(RB + 8), '0);                // R5 status
        op(0, 1, AW'(0), '0);                     // R6
        op(0, 1, AW'(RB + 4), '0);                // R6
        op(1, 1, AW'(3), 32'hFFFF_FFFF);          // R7 misaligned
        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            int sel;
            sel = $urandom_range(0, 9);
            a = (sel < 7) ? addrs[sel] : AW'($urandom);
            d = $urandom;
            if ($urandom_range(0, 3) == 0) d = '1;
            op(1'($urandom), 1'($urandom), a, d);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule